// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave end of a serial EEPROM on an SPI bus. It watches the serial clock, chip select, data input and pause inputs through synchronizers clocked by a faster system clock. It decodes one-byte commands and collects a 16-bit address. It then either streams bytes out of an 8192-byte array or gathers up to one 32-byte page of write data. When the chip select is released after a clean write, it runs a self-timed busy cycle that is a parameter number of system clocks long. At the end of that cycle the gathered bytes are copied into the array.

Write permission comes from a separate protection unit. In the cycle where a page write or a lock-level write would be committed, the block raises a request that carries the page number and a status-write flag. It commits only if the unit grants in that same cycle. The two-bit lock level is held here and sent to the unit. The serial output leaves as a data bit plus an enable, so the pad can float the line.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0; after reset the status byte reads 0x00.
- R2: Clock idle-low and idle-high framing (modes 0 and 3) give identical results. Input is taken on rising SCK and output changes on falling SCK, most significant bit first.
- R3: Opcode 0x06 sets the write-enable flag (status bit 1) and 0x04 clears it; opcode 0x05 returns the status byte {0000, lock[1:0], write-enable, busy}, repeated for as long as clocks continue.
- R4: Opcode 0x03 takes a 16-bit address whose top 3 bits are ignored. It returns consecutive bytes and wraps from 0x1FFF to 0x0000.
- R5: Opcode 0x02 with the write-enable flag clear changes nothing.
- R6: Opcode 0x02 loads 1 or more bytes into the addressed 32-byte page. The low 5 address bits advance and wrap inside the page, and a later byte to the same slot replaces an earlier one.
- R7: A write is started only when chip select rises after a whole number of data bytes, at least one. A partial byte or an empty write changes nothing and leaves the write-enable flag set.
- R8: A started write holds status bit 0 at 1 for the parameter number of clocks, clears the write-enable flag, and then updates the array.
- R9: While busy, every command other than 0x05 is ignored and drives no output.
- R10: While `hold_n` is low, SCK and SI edges are ignored and the transfer resumes unchanged after release.
- R11: A commit raises `prot_req` with `prot_page` = address bits 12..5 and `prot_status` = 0 for data, 1 for lock writes. If `prot_ok` is low, nothing changes and write-enable stays set.
- R12: Opcode 0x01 followed by exactly one byte, with write-enable set, loads status bits 3..2 into `lock_lvl` and clears write-enable. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable for the pad |
| prot_req | output | 1 | Commit request to the protection unit |
| prot_status | output | 1 | Request concerns the lock level rather than data |
| prot_page | output | 8 | Page number of the pending data write |
| prot_ok | input | 1 | Grant from the protection unit, same cycle |
| lock_lvl | output | 2 | Stored lock level |

## Verification
The page loader is tried with a short write in the middle of a page, with a run that starts near the page end and wraps, and with a run longer than a page that overwrites its first slots. Together these separate a correct in-page wrap from a carry into the next page and from loss of overwritten bytes. Reads are tried across the top of the array with the unused address bits set, which exposes both a missing wrap and a decode that uses too many bits. Aborted writes (partial byte, no data, no enable, refused grant) are checked for unchanged contents and unchanged status. The same reads and writes are repeated in idle-high clock framing and with a pause in mid-byte.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     si,
  input  logic                     hold_n,
  output logic                     so_o,
  output logic                     so_oe,
  output logic                     prot_req,
  output logic                     prot_status,
  output logic [ADDR_W-PAGE_W-1:0] prot_page,
  input  logic                     prot_ok,
  output logic [1:0]               lock_lvl
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01, OP_READ = 8'h03, OP_WRITE = 8'h02;

  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_WDAT, PH_RDAT, PH_STAT, PH_WSR, PH_IDLE} ph_t;

  logic [1:0] sck_s, cs_s, si_s, hold_s;
  logic sck_p, cs_p;
  ph_t ph;
  logic [7:0] sh, tx;
  logic [2:0] bitc;
  logic abyte, rd_op, any_w, got_sr, wel, busy;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] widx;
  logic [PAGE-1:0] pm;
  logic [1:0] sr_new, bp;
  logic [TW-1:0] tmr;
  logic [7:0] pb [PAGE];
  logic [7:0] mem [DEPTH];

  wire sck_q = sck_s[1];
  wire cs_q  = cs_s[1];
  wire si_q  = si_s[1];
  wire held  = ~hold_s[1];
  wire rise    = sck_q & ~sck_p & ~cs_q & ~held;
  wire fall    = ~sck_q & sck_p & ~cs_q & ~held;
  wire cs_fall = ~cs_q & cs_p;
  wire cs_rise = cs_q & ~cs_p;
  wire [7:0] sh_n   = {sh[6:0], si_q};
  wire [7:0] status = {4'b0000, bp, wel, busy};
  wire [7:0] nb     = (ph == PH_RDAT) ? mem[addr] : status;
  wire byte_done = rise && bitc == 3'd7;
  wire wr_byte   = byte_done && ph == PH_WDAT;
  wire wr_cand   = cs_rise && ph == PH_WDAT && bitc == 3'd0 && any_w && wel;
  wire sr_cand   = cs_rise && ph == PH_WSR && bitc == 3'd0 && got_sr && wel;
  wire wr_last   = busy && tmr == TW'(1);

  assign prot_req    = wr_cand | sr_cand;
  assign prot_status = sr_cand;
  assign prot_page   = addr[ADDR_W-1:PAGE_W];
  assign lock_lvl    = bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; cs_s <= 2'b11; si_s <= '0; hold_s <= 2'b11;
      sck_p <= 1'b0; cs_p <= 1'b1;
      ph <= PH_IDLE; sh <= '0; tx <= '0; bitc <= '0;
      abyte <= 1'b0; rd_op <= 1'b0; any_w <= 1'b0; got_sr <= 1'b0;
      wel <= 1'b0; busy <= 1'b0; addr <= '0; widx <= '0; pm <= '0;
      sr_new <= '0; bp <= '0; tmr <= '0; so_o <= 1'b0; so_oe <= 1'b0;
    end else begin
      sck_s  <= {sck_s[0], sck};
      cs_s   <= {cs_s[0], cs_n};
      si_s   <= {si_s[0], si};
      hold_s <= {hold_s[0], hold_n};
      sck_p  <= sck_q;
      cs_p   <= cs_q;
      if (cs_q) so_oe <= 1'b0;

      if (cs_fall) begin
        ph <= PH_OPC; bitc <= '0; abyte <= 1'b0; any_w <= 1'b0; got_sr <= 1'b0;
        if (!busy) pm <= '0;
      end

      if (rise) begin
        sh   <= sh_n;
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          unique case (ph)
            PH_OPC: begin
              if (busy && sh_n != OP_RDSR) ph <= PH_IDLE;
              else begin
                unique case (sh_n)
                  OP_WREN: begin wel <= 1'b1; ph <= PH_IDLE; end
                  OP_WRDI: begin wel <= 1'b0; ph <= PH_IDLE; end
                  OP_RDSR: ph <= PH_STAT;
                  OP_WRSR: ph <= PH_WSR;
                  OP_READ, OP_WRITE: begin
                    ph <= PH_ADDR; abyte <= 1'b0; rd_op <= (sh_n == OP_READ);
                  end
                  default: ph <= PH_IDLE;
                endcase
              end
            end
            PH_ADDR: begin
              if (!abyte) begin
                addr[ADDR_W-1:8] <= sh_n[ADDR_W-9:0];
                abyte <= 1'b1;
              end else begin
                addr[7:0] <= sh_n;
                widx <= sh_n[PAGE_W-1:0];
                ph <= rd_op ? PH_RDAT : PH_WDAT;
              end
            end
            PH_WDAT: begin
              pm[widx] <= 1'b1; widx <= widx + 1'b1; any_w <= 1'b1;
            end
            PH_WSR: begin
              if (!got_sr) begin sr_new <= sh_n[3:2]; got_sr <= 1'b1; end
              else ph <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end

      if (fall) begin
        if (bitc == 3'd0 && (ph == PH_RDAT || ph == PH_STAT)) begin
          so_o  <= nb[7];
          tx    <= {nb[6:0], 1'b0};
          so_oe <= 1'b1;
          if (ph == PH_RDAT) addr <= addr + 1'b1;
        end else begin
          so_o <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end

      if (prot_req && prot_ok) begin
        wel <= 1'b0;
        if (prot_status) bp <= sr_new;
        else begin busy <= 1'b1; tmr <= TW'(WR_CYCLES); end
      end

      if (busy) begin
        tmr <= tmr - 1'b1;
        if (wr_last) begin busy <= 1'b0; pm <= '0; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) pb[widx] <= sh_n;
    if (wr_last)
      for (int i = 0; i < PAGE; i++)
        if (pm[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pb[i];
  end

  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !so_oe);
  p_no_wel_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_fall) |=> ($stable(bitc) && $stable(sh)));
  p_busy_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prot_req && prot_ok && !prot_status));
  p_lock_granted_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(prot_req && prot_ok && prot_status));
endmodule

// File: tb/test_spi_eeprom_slave.sv
`timescale 1ns/1ps
module test_spi_eeprom_slave;
  localparam int WRC  = 1500;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, deny = 1'b0;
  wire so_o, so_oe, prot_req, prot_status;
  wire [7:0] prot_page;
  wire [1:0] lock_lvl;
  wire prot_ok = !deny;

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(13), .PAGE_W(5), .WR_CYCLES(WRC)) i_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so_o(so_o), .so_oe(so_oe), .prot_req(prot_req), .prot_status(prot_status),
    .prot_page(prot_page), .prot_ok(prot_ok), .lock_lvl(lock_lvl));

  int checks = 0, errors = 0, cyc = 0, csh = 0, req_n = 0, t_commit = 0;
  logic [7:0] req_page = 8'h00;
  logic req_st = 1'b0;
  logic [7:0] mem_m [int];
  logic wel_m = 1'b0, busy_m = 1'b0;
  logic [1:0] bp_m = 2'b00;
  bit mode3 = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prot_req) begin req_n++; req_page = prot_page; req_st = prot_status; end
    if (cs_n) csh++; else csh = 0;
    if (csh >= 4 && rst_n) chk(so_oe == 1'b0, "R1 so_oe while deselected", int'(so_oe), 0);
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r, output logic oe);
    sck = 1'b0; si = b; waitc(HALF);
    r = so_o; oe = so_oe;
    sck = 1'b1; waitc(HALF);
  endtask

  task automatic holdpause();
    logic lvl;
    lvl = sck;
    hold_n = 1'b0; waitc(HALF);
    for (int k = 0; k < 4; k++) begin sck = ~sck; si = ~si; waitc(HALF); end
    sck = lvl; waitc(HALF);
    hold_n = 1'b1; waitc(HALF);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r, output logic seen, input int hold_at = -1);
    logic o, rb;
    seen = 1'b0; r = '0;
    for (int b = 7; b >= 0; b--) begin
      if (b == hold_at) holdpause();
      bitx(d[b], rb, o);
      r[b] = rb;
      seen = seen | o;
    end
  endtask

  task automatic send(input logic [7:0] d, input int hold_at = -1);
    logic [7:0] r; logic s;
    xfer(d, r, s, hold_at);
  endtask

  task automatic cs_begin();
    sck = mode3; waitc(HALF); cs_n = 1'b0; waitc(HALF);
  endtask

  task automatic cs_end();
    if (!mode3) sck = 1'b0;
    waitc(HALF); cs_n = 1'b1; waitc(2*HALF);
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0000, bp_m, wel_m, busy_m};
  endfunction

  task automatic cmd(input logic [7:0] op);
    cs_begin(); send(op); cs_end();
    if (!busy_m) begin
      if (op == 8'h06) wel_m = 1'b1;
      if (op == 8'h04) wel_m = 1'b0;
    end
  endtask

  task automatic rdsr_chk(input string req);
    logic [7:0] r; logic s;
    cs_begin(); send(8'h05); xfer(8'h00, r, s); cs_end();
    chk(r == exp_status(), req, int'(r), int'(exp_status()));
  endtask

  task automatic rd_chk(input int a, input int n, input string req, input bit ign = 0, input int hold_at = -1);
    logic [7:0] r, e; logic s;
    cs_begin(); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r, s, (i == 0) ? hold_at : -1);
      if (ign) chk(!s, req, int'(s), 0);
      else begin
        e = mem_m[(a + i) & 'h1FFF];
        chk(r == e, req, int'(r), int'(e));
      end
    end
    cs_end();
  endtask

  task automatic wr(input int a, input int n, input int seed, input int extra, input int hold_at = -1);
    int a13;
    logic r, o;
    logic [7:0] d [$];
    a13 = a & 'h1FFF;
    for (int i = 0; i < n; i++) d.push_back(8'((seed + i * 37) & 255));
    cs_begin(); send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) send(d[i], (i == 0) ? hold_at : -1);
    for (int i = 0; i < extra; i++) bitx(1'b1, r, o);
    cs_end();
    t_commit = cyc;
    if (wel_m && !busy_m && n > 0 && extra == 0 && !deny) begin
      for (int i = 0; i < n; i++) mem_m[(a13 & 'h1FE0) | ((a13 + i) & 31)] = d[i];
      wel_m = 1'b0; busy_m = 1'b1;
    end
  endtask

  task automatic wait_idle();
    while (cyc < t_commit + WRC + 10) waitc(1);
    busy_m = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] v, input int nbytes);
    cs_begin(); send(8'h01);
    for (int i = 0; i < nbytes; i++) send(v);
    cs_end();
    if (wel_m && !busy_m && nbytes == 1 && !deny) begin bp_m = v[3:2]; wel_m = 1'b0; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    waitc(10); rst_n = 1'b1; waitc(5);
    chk(so_oe == 1'b0, "R1 reset so_oe", int'(so_oe), 0);
    rdsr_chk("R1 status after reset");

    cmd(8'h06); rdsr_chk("R3 write enable set");
    cmd(8'h04); rdsr_chk("R3 write enable cleared");

    cmd(8'h06);
    r0 = req_n;
    wr('h0100, 4, 'h11, 0);
    chk(req_n == r0 + 1, "R11 one request", req_n - r0, 1);
    chk(req_page == 8'h08, "R11 page number", int'(req_page), 8);
    chk(req_st == 1'b0, "R11 data request", int'(req_st), 0);
    rdsr_chk("R8 busy and enable cleared");
    cmd(8'h06);
    rdsr_chk("R9 enable ignored while busy");
    rd_chk('h0100, 1, "R9 read ignored while busy", 1);
    wait_idle();
    rdsr_chk("R8 busy ends");
    rd_chk('h0100, 4, "R4 sequential read");

    wr('h0100, 2, 'h55, 0);
    rdsr_chk("R5 no enable status");
    rd_chk('h0100, 2, "R5 no enable data kept");

    cmd(8'h06); wr('h0000, 4, 'h20, 0); wait_idle();
    cmd(8'h06); wr('h1FFC, 8, 'h40, 0); wait_idle();
    rd_chk('h1FE0, 4, "R6 in-page wrap");
    rd_chk('hFFFC, 8, "R4 top bits ignored and array wrap");

    cmd(8'h06); wr('h0210, 34, 'h70, 0); wait_idle();
    rd_chk('h0200, 32, "R6 full page with overwrite");

    cmd(8'h06); wr('h0100, 2, 'h99, 3);
    rdsr_chk("R7 partial byte status");
    rd_chk('h0100, 2, "R7 partial byte data kept");
    wr('h0100, 0, 0, 0);
    rdsr_chk("R7 empty write status");
    cmd(8'h04);

    deny = 1'b1;
    cmd(8'h06); wr('h0100, 2, 'hA0, 0);
    rdsr_chk("R11 refused write status");
    rd_chk('h0100, 2, "R11 refused write data kept");
    deny = 1'b0;
    cmd(8'h04);

    cmd(8'h06); wrsr(8'h0C, 1);
    rdsr_chk("R12 lock level written");
    chk(lock_lvl == bp_m, "R12 lock output", int'(lock_lvl), int'(bp_m));
    wrsr(8'h04, 1);
    rdsr_chk("R12 lock write without enable");
    cmd(8'h06); wrsr(8'h04, 2);
    rdsr_chk("R12 two-byte lock write ignored");
    wrsr(8'h00, 1);
    rdsr_chk("R12 lock cleared");
    chk(lock_lvl == 2'b00, "R12 lock output cleared", int'(lock_lvl), 0);

    mode3 = 1'b1; sck = 1'b1; waitc(4*HALF);
    rd_chk('h0100, 4, "R2 idle-high read");
    cmd(8'h06); wr('h0104, 3, 'hB0, 0); wait_idle();
    rd_chk('h0100, 8, "R2 idle-high write then read");
    rdsr_chk("R2 idle-high status");

    cmd(8'h06); wr('h0300, 2, 'hC0, 0, 4); wait_idle();
    rd_chk('h0300, 2, "R10 pause in write and read", 0, 3);
    mode3 = 1'b0; sck = 1'b0; waitc(4*HALF);
    rd_chk('h0300, 2, "R10 pause in idle-low read", 0, 5);

    finish_run();
  end
endmodule